// File: doc/BRIEF.md
# Stack Call and Return Engine

This block carries out every operation of a simple processor that touches the stack. It can push or pop 1, 2, 4 or 8 bytes. It can call a subroutine with the return address saved on the stack, call with the return address handed back as a link value, return from a subroutine, and prepare the stack at program start. The block owns architectural register 0, the stack pointer, and presents it on an output. The stack grows toward lower addresses. A push stores first and then moves the pointer down. A pop moves the pointer up first and then reads.

A caller presents an operation together with a data operand, a target address and the address of the following instruction. Operations that need memory raise a request on a byte-addressed port and hold it until the memory acknowledges. On that acknowledge the block updates the stack pointer. One cycle later it reports the result: popped data, a program-counter redirect, or a link value. A register-link call needs no memory and reports its result in the cycle after it is accepted.

Top module: `stk_callret_unit`

## Requirements
- R1: After reset the stack pointer equals the parameter SP_RESET (default 0), and busy, mem_req, pop_valid, redirect and link_valid are all low.
- R2: A push (op_code 0) with size code op_size (0=1, 1=2, 2=4, 3=8 bytes) writes op_data little-endian at mem_addr = SP, with mem_be set on the low `size` lanes and byte k of the operand on lane k. On the acknowledge, SP drops by the size.
- R3: A pop (op_code 1) reads at mem_addr = SP+size with the same enable pattern, and SP becomes SP+size. pop_valid then pulses with pop_data equal to the low `size` bytes of mem_rdata, and the bytes above them are zero.
- R4: A call (op_code 2) writes op_next_pc as a 4-byte word at SP and lowers SP by 4. It then pulses redirect with redirect_pc = op_target.
- R5: A register-link call (op_code 3) makes no memory request and leaves SP unchanged. In the cycle after acceptance it pulses link_valid and redirect together, with link_value = op_next_pc and redirect_pc = op_target.
- R6: A return (op_code 4) reads a 4-byte word at SP+4 and raises SP by 4. It then pulses redirect with redirect_pc equal to the low 32 bits of mem_rdata.
- R7: Initialization (op_code 5) writes op_next_pc as a word at LAST_ADDR-7, leaves SP at LAST_ADDR-11, and redirects to op_target.
- R8: busy rises in the cycle after a memory operation is accepted and falls after the edge that samples mem_ack. SP changes at that same edge. The result pulses last exactly one cycle after it.
- R9: While busy, the request fields stay unchanged. op_valid is ignored, and a mem_ack seen without an outstanding request changes nothing.
- R10: Stack-pointer and address arithmetic wraps modulo 2^32. A byte push at SP=0 leaves SP=0xFFFFFFFF.
- R11: op_code values 6 and 7 are ignored: no request, no pulse, and SP is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_code | input | 3 | Operation select (0 push, 1 pop, 2 call, 3 link call, 4 return, 5 init) |
| op_size | input | 2 | Push/pop size code |
| op_data | input | 64 | Push operand |
| op_target | input | 32 | Jump target for calls and init |
| op_next_pc | input | 32 | Address of the following instruction |
| busy | output | 1 | Memory operation outstanding |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Lowest byte address of the access |
| mem_be | output | 8 | Byte-lane enables, lane 0 at mem_addr |
| mem_wdata | output | 64 | Write data, lane k for mem_addr+k |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 64 | Read data, lane k from mem_addr+k |
| stack_ptr | output | 32 | Stack pointer (register 0) |
| pop_valid | output | 1 | Pop result pulse |
| pop_data | output | 64 | Popped operand, zero-extended |
| redirect | output | 1 | Program-counter redirect pulse |
| redirect_pc | output | 32 | Redirect target |
| link_valid | output | 1 | Link value pulse |
| link_value | output | 32 | Return address for the link call |

## Verification
The bench draws a random mix of pushes and pops of all four sizes interleaved with calls, link calls, returns, initializations and undefined codes. It compares every request and result against a byte-level memory model. Push/pop pairs of equal size show whether the address and the pointer step are symmetric. Mixed sizes, and read data with garbage in the upper lanes, separate correct lane masking from masking that only happens to work. Randomized acknowledge delays, with extra operations offered during the wait, show whether state moves only at the acknowledge. The directed cases at SP=0 and the initialization address pin down wrap-around and the fixed starting offset.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [2:0] {
      STK_PUSH = 3'd0,
      STK_POP  = 3'd1,
      STK_CALL = 3'd2,
      STK_LINK = 3'd3,
      STK_RET  = 3'd4,
      STK_INIT = 3'd5
   } stk_op_e;

   typedef enum logic [1:0] {
      SPM_DOWN   = 2'd0,
      SPM_UP     = 2'd1,
      SPM_RESEED = 2'd2,
      SPM_HOLD   = 2'd3
   } sp_mode_e;

   localparam logic [1:0] SZ_WORD = 2'd2;

   function automatic logic forces_word(input logic [2:0] code);
      return (code == STK_CALL) || (code == STK_RET) || (code == STK_INIT);
   endfunction

   function automatic logic code_legal(input logic [2:0] code);
      return code <= STK_INIT;
   endfunction

endpackage

// File: rtl/stk_sizer.sv
module stk_sizer #(
   parameter  int LANES = 8,
   localparam int CW    = $clog2(LANES) + 1
) (
   input  logic [1:0]       size_code,
   output logic [CW-1:0]    byte_cnt,
   output logic [LANES-1:0] lane_en
);

   initial begin
      assert (LANES == 8) else $error("stk_sizer: LANES must be 8");
   end

   assign byte_cnt = CW'(1) << size_code;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_en[g] = (CW'(g) < byte_cnt);
   end

endmodule

// File: rtl/stk_sp_reg.sv
module stk_sp_reg
   import stk_pkg::*;
#(
   parameter int            AW       = 32,
   parameter int            CW       = 4,
   parameter logic [AW-1:0] SP_RESET = '0,
   parameter logic [AW-1:0] INIT_SP  = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          commit,
   input  sp_mode_e      mode,
   input  logic [CW-1:0] amount,
   output logic [AW-1:0] sp
);

   initial begin
      assert (AW >= CW) else $error("stk_sp_reg: AW too small");
   end

   logic [AW-1:0] step;
   assign step = AW'(amount);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp <= SP_RESET;
      end else if (commit) begin
         case (mode)
            SPM_DOWN:   sp <= sp - step;
            SPM_UP:     sp <= sp + step;
            SPM_RESEED: sp <= INIT_SP - step;
            default:    sp <= sp;
         endcase
      end
   end

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
   import stk_pkg::*;
#(
   parameter int            AW      = 32,
   parameter int            DW      = 64,
   parameter int            LANES   = 8,
   parameter int            CW      = 4,
   parameter logic [AW-1:0] INIT_SP = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [2:0]       op_code,
   input  logic [DW-1:0]    op_data,
   input  logic [AW-1:0]    op_target,
   input  logic [AW-1:0]    op_next_pc,
   input  logic [CW-1:0]    cnt,
   input  logic [LANES-1:0] be,
   input  logic [AW-1:0]    sp,
   output logic             busy,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [LANES-1:0] mem_be,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_ack,
   input  logic [DW-1:0]    mem_rdata,
   output logic             commit,
   output sp_mode_e         mode,
   output logic [CW-1:0]    amount,
   output logic             pop_valid,
   output logic [DW-1:0]    pop_data,
   output logic             redirect,
   output logic [AW-1:0]    redirect_pc,
   output logic             link_valid,
   output logic [AW-1:0]    link_value
);

   initial begin
      assert (DW == 8 * LANES) else $error("stk_ctrl: DW must be 8*LANES");
      assert (DW >= AW) else $error("stk_ctrl: DW must hold an address");
   end

   logic             busy_q;
   logic [2:0]       op_q;
   logic [AW-1:0]    addr_q;
   logic [LANES-1:0] be_q;
   logic [CW-1:0]    cnt_q;
   logic [DW-1:0]    wdata_q;
   logic [AW-1:0]    tgt_q;
   logic             we_q;

   logic             accept;
   logic [AW-1:0]    addr_n;
   logic [DW-1:0]    wdata_n;
   logic             we_n;
   logic [DW-1:0]    lane_mask;

   assign accept = op_valid && !busy_q && code_legal(op_code);

   always_comb begin
      case (op_code)
         STK_PUSH, STK_CALL: addr_n = sp;
         STK_POP, STK_RET:   addr_n = sp + AW'(cnt);
         STK_INIT:           addr_n = INIT_SP;
         default:            addr_n = sp;
      endcase
      case (op_code)
         STK_PUSH:           wdata_n = op_data;
         STK_CALL, STK_INIT: wdata_n = DW'(op_next_pc);
         default:            wdata_n = '0;
      endcase
      we_n = (op_code == STK_PUSH) || (op_code == STK_CALL) || (op_code == STK_INIT);
   end

   for (genvar g = 0; g < LANES; g++) begin : g_mask
      assign lane_mask[8*g +: 8] = {8{be_q[g]}};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         op_q        <= '0;
         addr_q      <= '0;
         be_q        <= '0;
         cnt_q       <= '0;
         wdata_q     <= '0;
         tgt_q       <= '0;
         we_q        <= 1'b0;
         pop_valid   <= 1'b0;
         pop_data    <= '0;
         redirect    <= 1'b0;
         redirect_pc <= '0;
         link_valid  <= 1'b0;
         link_value  <= '0;
      end else begin
         pop_valid  <= 1'b0;
         redirect   <= 1'b0;
         link_valid <= 1'b0;
         if (accept) begin
            if (op_code == STK_LINK) begin
               link_valid  <= 1'b1;
               link_value  <= op_next_pc;
               redirect    <= 1'b1;
               redirect_pc <= op_target;
            end else begin
               busy_q  <= 1'b1;
               op_q    <= op_code;
               addr_q  <= addr_n;
               be_q    <= be;
               cnt_q   <= cnt;
               wdata_q <= wdata_n;
               tgt_q   <= op_target;
               we_q    <= we_n;
            end
         end else if (busy_q && mem_ack) begin
            busy_q <= 1'b0;
            case (op_q)
               STK_POP: begin
                  pop_valid <= 1'b1;
                  pop_data  <= mem_rdata & lane_mask;
               end
               STK_RET: begin
                  redirect    <= 1'b1;
                  redirect_pc <= mem_rdata[AW-1:0];
               end
               STK_CALL, STK_INIT: begin
                  redirect    <= 1'b1;
                  redirect_pc <= tgt_q;
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (op_q)
         STK_PUSH, STK_CALL: mode = SPM_DOWN;
         STK_POP, STK_RET:   mode = SPM_UP;
         STK_INIT:           mode = SPM_RESEED;
         default:            mode = SPM_HOLD;
      endcase
   end

   assign commit    = busy_q && mem_ack;
   assign amount    = cnt_q;
   assign busy      = busy_q;
   assign mem_req   = busy_q;
   assign mem_we    = we_q;
   assign mem_addr  = addr_q;
   assign mem_be    = be_q;
   assign mem_wdata = wdata_q;

   // R9: request fields held while waiting for the acknowledge
   a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_we));

   // R9: offered operations during a wait do not end the wait
   a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      busy && op_valid && !mem_ack |=> busy);

   // R8: a pop result only follows an acknowledged request
   a_r8_pop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid |-> $past(mem_ack) && $past(busy));

   // R5: link value and redirect pulse together, without a memory wait
   a_r5_link_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      link_valid |-> redirect && !$past(busy));

endmodule

// File: rtl/stk_callret_unit.sv
module stk_callret_unit
   import stk_pkg::*;
#(
   parameter int                AW        = 32,
   parameter int                DW        = 64,
   parameter logic [AW-1:0]     SP_RESET  = '0,
   parameter logic [AW-1:0]     LAST_ADDR = 32'h000F_FFFF,
   localparam int               LANES     = DW / 8,
   localparam int               CW        = $clog2(LANES) + 1,
   localparam logic [AW-1:0]    INIT_SP   = LAST_ADDR - AW'(7)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [2:0]       op_code,
   input  logic [1:0]       op_size,
   input  logic [DW-1:0]    op_data,
   input  logic [AW-1:0]    op_target,
   input  logic [AW-1:0]    op_next_pc,
   output logic             busy,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [LANES-1:0] mem_be,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_ack,
   input  logic [DW-1:0]    mem_rdata,
   output logic [AW-1:0]    stack_ptr,
   output logic             pop_valid,
   output logic [DW-1:0]    pop_data,
   output logic             redirect,
   output logic [AW-1:0]    redirect_pc,
   output logic             link_valid,
   output logic [AW-1:0]    link_value
);

   initial begin
      assert (DW == 64) else $error("stk_callret_unit: DW must be 64");
      assert (AW >= 8 && AW <= DW) else $error("stk_callret_unit: AW out of range");
   end

   logic [1:0]       eff_size;
   logic [CW-1:0]    cnt;
   logic [LANES-1:0] be;
   logic             commit;
   sp_mode_e         mode;
   logic [CW-1:0]    amount;

   assign eff_size = forces_word(op_code) ? SZ_WORD : op_size;

   stk_sizer #(.LANES(LANES)) u_sizer (
      .size_code (eff_size),
      .byte_cnt  (cnt),
      .lane_en   (be)
   );

   stk_sp_reg #(
      .AW(AW), .CW(CW), .SP_RESET(SP_RESET), .INIT_SP(INIT_SP)
   ) u_sp (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (commit),
      .mode   (mode),
      .amount (amount),
      .sp     (stack_ptr)
   );

   stk_ctrl #(
      .AW(AW), .DW(DW), .LANES(LANES), .CW(CW), .INIT_SP(INIT_SP)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_valid    (op_valid),
      .op_code     (op_code),
      .op_data     (op_data),
      .op_target   (op_target),
      .op_next_pc  (op_next_pc),
      .cnt         (cnt),
      .be          (be),
      .sp          (stack_ptr),
      .busy        (busy),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_be      (mem_be),
      .mem_wdata   (mem_wdata),
      .mem_ack     (mem_ack),
      .mem_rdata   (mem_rdata),
      .commit      (commit),
      .mode        (mode),
      .amount      (amount),
      .pop_valid   (pop_valid),
      .pop_data    (pop_data),
      .redirect    (redirect),
      .redirect_pc (redirect_pc),
      .link_valid  (link_valid),
      .link_value  (link_value)
   );

   // R2: after an acknowledged write the pointer sits just below the written span
   a_r2_push_sp: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && mem_we |=>
         stack_ptr == ($past(mem_addr) - AW'($countones($past(mem_be)))));

   // R3: after an acknowledged read the pointer equals the read address
   a_r3_pop_sp: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && !mem_we |=> stack_ptr == $past(mem_addr));

   // R8: the pointer moves only on an acknowledged request
   a_r8_sp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && mem_ack) |=> $stable(stack_ptr));

   // R11: undefined codes never start a request
   a_r11_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && op_valid && (op_code > 3'd5) |=> !busy && !link_valid);

endmodule

// File: tb/stk_callret_unit_tb.sv
`timescale 1ns/1ps
module stk_callret_unit_tb;

   localparam logic [31:0] LAST = 32'h000F_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = '0;
   logic [1:0]  op_size = '0;
   logic [63:0] op_data = '0;
   logic [31:0] op_target = '0;
   logic [31:0] op_next_pc = '0;
   logic        busy, mem_req, mem_we;
   logic [31:0] mem_addr;
   logic [7:0]  mem_be;
   logic [63:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic [31:0] stack_ptr;
   logic        pop_valid, redirect, link_valid;
   logic [63:0] pop_data;
   logic [31:0] redirect_pc, link_value;

   int checks = 0;
   int fails  = 0;
   logic [31:0] sp_m;
   logic [7:0]  bmem [logic [31:0]];

   always #2.5 clk = ~clk;

   stk_callret_unit u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_size(op_size), .op_data(op_data), .op_target(op_target),
      .op_next_pc(op_next_pc), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .stack_ptr(stack_ptr),
      .pop_valid(pop_valid), .pop_data(pop_data), .redirect(redirect),
      .redirect_pc(redirect_pc), .link_valid(link_valid), .link_value(link_value)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] rd_b(input logic [31:0] a);
      return bmem.exists(a) ? bmem[a] : 8'h00;
   endfunction

   function automatic int nbytes(input logic [2:0] op, input logic [1:0] sz);
      if (op == 3'd2 || op == 3'd4 || op == 3'd5) return 4;
      return 1 << sz;
   endfunction

   function automatic logic [7:0] exp_be(input int n);
      logic [7:0] b = '0;
      for (int k = 0; k < n; k++) b[k] = 1'b1;
      return b;
   endfunction

   task automatic run_op(input logic [2:0] op, input logic [1:0] sz, input logic [63:0] data,
                         input logic [31:0] tgt, input logic [31:0] npc,
                         input int delay, input bit poke);
      int n;
      logic [31:0] a_e;
      logic        we_e;
      logic [63:0] rd_e;
      logic [63:0] garbage;
      n    = nbytes(op, sz);
      we_e = (op == 3'd0 || op == 3'd2 || op == 3'd5);
      case (op)
         3'd0, 3'd2: a_e = sp_m;
         3'd1, 3'd4: a_e = sp_m + 32'(n);
         default:    a_e = LAST - 32'd7;
      endcase
      @(negedge clk);
      op_valid = 1'b1; op_code = op; op_size = sz; op_data = data;
      op_target = tgt; op_next_pc = npc;
      @(negedge clk);
      op_valid = 1'b0;
      if (op == 3'd3) begin
         chk(link_valid && redirect, "R5 pulses", {link_valid, redirect}, 2'b11);
         chk(link_value == npc, "R5 link_value", link_value, npc);
         chk(redirect_pc == tgt, "R5 redirect_pc", redirect_pc, tgt);
         chk(!mem_req && !busy && stack_ptr == sp_m, "R5 no access", stack_ptr, sp_m);
         return;
      end
      if (op > 3'd5) begin
         chk(!mem_req && !busy && !redirect && !link_valid && !pop_valid && stack_ptr == sp_m,
             "R11 ignored", {mem_req, busy, redirect, link_valid, pop_valid, stack_ptr},
             {5'b0, sp_m});
         return;
      end
      chk(mem_req && busy, "R8 busy after accept", {mem_req, busy}, 2'b11);
      chk(mem_addr == a_e, "R2 R3 address", mem_addr, a_e);
      chk(mem_we == we_e && mem_be == exp_be(n), "R2 we/be", {mem_we, mem_be}, {we_e, exp_be(n)});
      if (we_e) begin
         for (int k = 0; k < n; k++) begin
            logic [7:0] eb;
            eb = (op == 3'd0) ? data[8*k +: 8] : npc[8*k +: 8];
            chk(mem_wdata[8*k +: 8] == eb, "R2 R4 R7 write byte", mem_wdata[8*k +: 8], eb);
            bmem[a_e + 32'(k)] = eb;
         end
      end
      rd_e = '0;
      for (int k = 0; k < n; k++) rd_e[8*k +: 8] = rd_b(a_e + 32'(k));
      for (int d = 0; d < delay; d++) begin
         if (poke && d == 0) begin
            op_valid = 1'b1; op_code = 3'd0; op_size = 2'd3;
         end
         @(negedge clk);
         op_valid = 1'b0;
         chk(busy && mem_addr == a_e && stack_ptr == sp_m, "R9 held while waiting",
             {busy, mem_addr, stack_ptr}, {1'b1, a_e, sp_m});
      end
      garbage = {$urandom, $urandom};
      for (int k = 0; k < n; k++) garbage[8*k +: 8] = rd_e[8*k +: 8];
      mem_rdata = garbage;
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
      case (op)
         3'd0, 3'd2: sp_m = a_e - 32'(n);
         3'd1, 3'd4: sp_m = a_e;
         default:    sp_m = a_e - 32'd4;
      endcase
      chk(stack_ptr == sp_m, "R2 R3 R4 R6 R7 R10 stack pointer", stack_ptr, sp_m);
      chk(!busy && !mem_req, "R8 busy drops", {busy, mem_req}, 2'b00);
      if (op == 3'd1) begin
         chk(pop_valid && pop_data == rd_e, "R3 pop data", pop_data, rd_e);
      end else if (op == 3'd4) begin
         chk(redirect && redirect_pc == rd_e[31:0], "R6 return target", redirect_pc, rd_e[31:0]);
      end else if (op == 3'd2 || op == 3'd5) begin
         chk(redirect && redirect_pc == tgt, "R4 R7 redirect", redirect_pc, tgt);
      end else begin
         chk(!redirect && !pop_valid, "R2 no pulse on push", {redirect, pop_valid}, 2'b00);
      end
      @(negedge clk);
      chk(!redirect && !pop_valid && !link_valid && !mem_req, "R8 R9 pulse ends, no stray op",
          {redirect, pop_valid, link_valid, mem_req}, 4'b0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd2024));
      sp_m = 32'h0;
      repeat (3) @(negedge clk);
      chk(stack_ptr == 32'h0 && !busy && !mem_req && !pop_valid && !redirect && !link_valid,
          "R1 reset state", {busy, mem_req, stack_ptr}, 34'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(stack_ptr == 32'h0 && !busy, "R1 after release", stack_ptr, 32'h0);

      // R10 wrap below zero and back
      run_op(3'd0, 2'd0, 64'hA5, 0, 0, 0, 0);
      chk(stack_ptr == 32'hFFFF_FFFF, "R10 wrap", stack_ptr, 32'hFFFF_FFFF);
      run_op(3'd1, 2'd0, 0, 0, 0, 1, 0);
      chk(pop_data == 64'hA5, "R3 byte round trip", pop_data, 64'hA5);
      // R7 init then symmetric double/half pairs
      run_op(3'd5, 2'd0, 0, 32'h0000_0100, 32'h0000_0004, 2, 1);
      chk(stack_ptr == LAST - 32'd11, "R7 final SP", stack_ptr, LAST - 32'd11);
      run_op(3'd0, 2'd3, 64'h1122_3344_5566_7788, 0, 0, 3, 1);
      run_op(3'd0, 2'd1, 64'hFFFF_FFFF_FFFF_BEEF, 0, 0, 0, 0);
      run_op(3'd1, 2'd1, 0, 0, 0, 1, 0);
      chk(pop_data == 64'hBEEF, "R3 half zero-extended", pop_data, 64'hBEEF);
      run_op(3'd1, 2'd3, 0, 0, 0, 2, 0);
      chk(pop_data == 64'h1122_3344_5566_7788, "R3 double round trip", pop_data, 64'h1122_3344_5566_7788);
      // R4/R6 call then return to the saved address
      run_op(3'd2, 2'd0, 0, 32'h0000_2000, 32'h0000_0ABC, 1, 0);
      run_op(3'd4, 2'd0, 0, 0, 0, 2, 1);
      chk(redirect_pc == 32'h0000_0ABC, "R6 returns to call site", redirect_pc, 32'h0ABC);
      run_op(3'd3, 2'd0, 0, 32'h0000_3000, 32'h0000_0DEF, 0, 0);
      run_op(3'd6, 2'd0, 0, 0, 0, 0, 0);
      run_op(3'd7, 2'd3, 0, 0, 0, 0, 0);
      // R9 stray acknowledge while idle
      @(negedge clk); mem_ack = 1'b1;
      @(negedge clk); mem_ack = 1'b0;
      chk(stack_ptr == sp_m && !pop_valid && !redirect && !busy, "R9 stray ack",
          stack_ptr, sp_m);

      for (int i = 0; i < 400; i++) begin
         int r;
         logic [2:0] op;
         r = int'($urandom % 16);
         if (r < 5) op = 3'd0;
         else if (r < 9) op = 3'd1;
         else if (r < 11) op = 3'd2;
         else if (r < 12) op = 3'd3;
         else if (r < 14) op = 3'd4;
         else if (r < 15) op = 3'd5;
         else op = 3'd6 + 3'($urandom % 2);
         run_op(op, 2'($urandom), {$urandom, $urandom}, $urandom, $urandom,
                int'($urandom % 4), ($urandom % 3) == 0);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule